// File: doc/BRIEF.md
# Digital Component Video Stream Receiver

This block takes in a 27 MHz digital component video stream that follows the BT.656 format. The input is 10 bits wide. An 8-bit source is connected with its two least significant bits tied to zero.

The block watches the stream for timing reference codes and decodes the field, vertical-blanking and horizontal flags from each one. It checks the code's protection bits and keeps a count of protection failures over each frame. That count saturates, and it is published as a status value once per frame.

Inside the active part of each line, the samples arrive in the repeating order Cb, Y, Cr, Y. The block splits them into co-timed Y, Cb and Cr outputs with a valid strobe. One-cycle pulses mark the start-of-active-video code, the end-of-active-video code and the start of each frame, so a downstream sync generator can lock to the incoming line and field timing.

Top module: `itu_stream_rx`

## Requirements
- R1: A timing reference code is four consecutive words: upper eight bits (9:2) equal FF, then 00, then 00, then a code word. Both a 10-bit 3FF preamble and an 8-bit-padded 3FC preamble are accepted. A sequence that breaks this pattern yields no pulse.
- R2: The code word carries the field flag in bit 8, the vertical flag in bit 7 and the horizontal flag in bit 6. These appear on `fieldFlag`, `vertFlag` and `horzFlag` in the cycle after the code word and hold until the next code.
- R3: A code with bit 6 = 0 gives a one-cycle `savPulse`, and a code with bit 6 = 1 gives a one-cycle `eavPulse`. Either pulse appears in the same cycle the flags update, and the two are never high together.
- R4: Bits 5..2 of the code word must equal {V^H, F^H, F^V, F^V^H}. A mismatch in any one of these bits raises `parityErr` together with that code's start or end pulse.
- R5: `frameStart` pulses when a code has F = 0 and the previous code had F = 1. At that moment `errCount` takes the number of failures seen since the previous frame start, not counting this code. The running count then restarts at 1 if this code failed, or at 0 if it did not. `errCount` changes at no other time.
- R6: The running failure count stops at 255 and does not wrap.
- R7: After a start-of-active code, the words are taken as Cb, Y0, Cr, Y1, repeating. In the cycle after Y1, `pixValid` is high with Y0, Cb and Cr on the outputs. Two cycles later, `pixValid` is high again with Y1 and the same Cb and Cr. `pixValid` is never high in two consecutive cycles.
- R8: Any word whose upper eight bits are FF ends capture. The next start-of-active code restarts the phase, so the following word is taken as Cb whatever the earlier alignment was.
- R9: Words between an end-of-active code and the next start-of-active code produce no `pixValid`, and they leave `yOut`, `cbOut` and `crOut` unchanged.
- R10: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vidIn | input | 10 | Multiplexed video words; for an 8-bit source, bits 1:0 are tied to 0 |
| yOut | output | 10 | Luma sample |
| cbOut | output | 10 | Blue-difference sample, co-timed with `yOut` |
| crOut | output | 10 | Red-difference sample, co-timed with `yOut` |
| pixValid | output | 1 | Output sample strobe |
| savPulse | output | 1 | Start-of-active code seen |
| eavPulse | output | 1 | End-of-active code seen |
| fieldFlag | output | 1 | Field flag from the last code |
| vertFlag | output | 1 | Vertical blanking flag from the last code |
| horzFlag | output | 1 | Horizontal flag from the last code |
| parityErr | output | 1 | Protection mismatch on the current code |
| frameStart | output | 1 | Field flag fell from 1 to 0 |
| errCount | output | 8 | Failures counted over the previous frame |

## Verification
The hardest state to reach from the ports is a saturated failure counter that is then published at a frame boundary. Getting there takes more than 255 corrupted codes, all carrying F = 1, followed by one clean F = 0 code. The stimulus streams 300 such codes and confirms that `errCount` does not move until the boundary, and that it then reads 255.

A second subtle case is a frame-boundary code that itself fails its check. That error must land in the new frame's count, not in the published one. The bench checks this by reading the count out two frame boundaries later.

Capture alignment is exercised by cutting a line short in mid-group and starting a fresh line directly after it.

// File: rtl/itu_rx_pkg.sv
package itu_rx_pkg;
  // capture strobes from control to datapath, one per sample phase
  typedef struct packed {
    logic capCb;
    logic capY0;
    logic capCr;
    logic capY1;
  } capStrobe_t;
endpackage

// File: rtl/itu_rx_ctrl.sv
module itu_rx_ctrl
  import itu_rx_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ERR_W  = 8,
  parameter int HIST_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  output capStrobe_t        strobe,
  output logic              fieldFlag,
  output logic              vertFlag,
  output logic              horzFlag,
  output logic              savPulse,
  output logic              eavPulse,
  output logic              parityErr,
  output logic              frameStart,
  output logic [ERR_W-1:0]  errCount
);
  localparam logic [CODE_W-1:0] CODE_ONES = '1;
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;
  localparam logic [ERR_W-1:0]  ERR_MAX   = '1;
  localparam logic [ERR_W-1:0]  ERR_ONE   = ERR_W'(1);
  localparam int                PH_W      = 2;

  // preamble history, index 0 is the most recent word
  logic [HIST_N-1:0][CODE_W-1:0] hist;
  logic [HIST_N-1:0]             histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= {hist[HIST_N-2:0], codeIn};
  end

  genvar gi;
  generate
    for (gi = 0; gi < HIST_N; gi++) begin : g_hist
      if (gi == HIST_N - 1) begin : g_ones
        assign histOk[gi] = (hist[gi] == CODE_ONES);
      end else begin : g_zero
        assign histOk[gi] = (hist[gi] == CODE_ZERO);
      end
    end
  endgenerate

  logic       trsNow, preambleNow;
  logic       bitF, bitV, bitH;
  logic [3:0] protGot, protExp;
  logic       protBad, fallNow;

  assign trsNow      = &histOk;
  assign preambleNow = (codeIn == CODE_ONES);
  assign bitF        = codeIn[CODE_W-2];
  assign bitV        = codeIn[CODE_W-3];
  assign bitH        = codeIn[CODE_W-4];
  assign protGot     = codeIn[CODE_W-5:CODE_W-8];
  assign protExp     = {bitV ^ bitH, bitF ^ bitH, bitF ^ bitV, bitF ^ bitV ^ bitH};
  assign protBad     = trsNow && (protGot != protExp);
  assign fallNow     = trsNow && fieldFlag && !bitF;

  // flags and pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldFlag  <= 1'b0;
      vertFlag   <= 1'b0;
      horzFlag   <= 1'b0;
      savPulse   <= 1'b0;
      eavPulse   <= 1'b0;
      parityErr  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      savPulse   <= trsNow && !bitH;
      eavPulse   <= trsNow && bitH;
      parityErr  <= protBad;
      frameStart <= fallNow;
      if (trsNow) begin
        fieldFlag <= bitF;
        vertFlag  <= bitV;
        horzFlag  <= bitH;
      end
    end
  end

  // per-frame failure count with saturation
  logic [ERR_W-1:0] errRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errRun   <= '0;
      errCount <= '0;
    end else if (fallNow) begin
      errCount <= errRun;
      errRun   <= protBad ? ERR_ONE : '0;
    end else if (protBad && (errRun != ERR_MAX)) begin
      errRun <= errRun + ERR_ONE;
    end
  end

  // sample phase tracking within the active line
  logic            active;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (trsNow && !bitH) begin
      active <= 1'b1;
      phase  <= '0;
    end else if (preambleNow) begin
      active <= 1'b0;
    end else if (active) begin
      phase <= phase + PH_W'(1);
    end
  end

  logic takeNow;
  assign takeNow = active && !preambleNow;

  always_comb begin
    strobe       = '0;
    strobe.capCb = takeNow && (phase == PH_W'(0));
    strobe.capY0 = takeNow && (phase == PH_W'(1));
    strobe.capCr = takeNow && (phase == PH_W'(2));
    strobe.capY1 = takeNow && (phase == PH_W'(3));
  end
endmodule

// File: rtl/itu_rx_dpath.sv
module itu_rx_dpath
  import itu_rx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidIn,
  input  capStrobe_t        strobe,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut,
  output logic              pixValid
);
  localparam int DUE_W = 2;

  logic [DATA_W-1:0] cbHold, y0Hold, crHold, y1Hold;
  logic [DUE_W-1:0]  secondDue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbHold <= '0;
      y0Hold <= '0;
      crHold <= '0;
    end else begin
      if (strobe.capCb) cbHold <= vidIn;
      if (strobe.capY0) y0Hold <= vidIn;
      if (strobe.capCr) crHold <= vidIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secondDue <= '0;
      y1Hold    <= '0;
      yOut      <= '0;
      cbOut     <= '0;
      crOut     <= '0;
      pixValid  <= 1'b0;
    end else begin
      secondDue <= {secondDue[DUE_W-2:0], strobe.capY1};
      pixValid  <= 1'b0;
      if (strobe.capY1) begin
        yOut     <= y0Hold;
        cbOut    <= cbHold;
        crOut    <= crHold;
        y1Hold   <= vidIn;
        pixValid <= 1'b1;
      end else if (secondDue[DUE_W-1]) begin
        yOut     <= y1Hold;
        pixValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/itu_stream_rx.sv
module itu_stream_rx
  import itu_rx_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut,
  output logic              pixValid,
  output logic              savPulse,
  output logic              eavPulse,
  output logic              fieldFlag,
  output logic              vertFlag,
  output logic              horzFlag,
  output logic              parityErr,
  output logic              frameStart,
  output logic [ERR_W-1:0]  errCount
);
  localparam int CODE_W = 8;

  capStrobe_t strobe;

  itu_rx_ctrl #(.CODE_W(CODE_W), .ERR_W(ERR_W), .HIST_N(3)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .codeIn     (vidIn[DATA_W-1:DATA_W-CODE_W]),
    .strobe     (strobe),
    .fieldFlag  (fieldFlag),
    .vertFlag   (vertFlag),
    .horzFlag   (horzFlag),
    .savPulse   (savPulse),
    .eavPulse   (eavPulse),
    .parityErr  (parityErr),
    .frameStart (frameStart),
    .errCount   (errCount)
  );

  itu_rx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .vidIn    (vidIn),
    .strobe   (strobe),
    .yOut     (yOut),
    .cbOut    (cbOut),
    .crOut    (crOut),
    .pixValid (pixValid)
  );
endmodule

// File: rtl/itu_stream_rx_chk.sv
module itu_stream_rx_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixValid,
  input logic             savPulse,
  input logic             eavPulse,
  input logic             fieldFlag,
  input logic             vertFlag,
  input logic             horzFlag,
  input logic             parityErr,
  input logic             frameStart,
  input logic [ERR_W-1:0] errCount
);
  // R3: start and end pulses are exclusive
  a_r3_sav_eav_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(savPulse && eavPulse));

  // R7: valid strobe never in consecutive cycles
  a_r7_valid_gap: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);

  // R2: flags only move with a decoded code
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(savPulse || eavPulse) |-> ($stable(fieldFlag) && $stable(vertFlag) && $stable(horzFlag)));

  // R4: a protection failure belongs to a decoded code
  a_r4_err_on_code: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> (savPulse || eavPulse));

  // R5: frame start only on a falling field flag carried by a code
  a_r5_frame_fall: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> ((savPulse || eavPulse) && !fieldFlag && $past(fieldFlag)));

  // R5: published count moves only at a frame start
  a_r5_count_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCount) |-> frameStart);
endmodule

bind itu_stream_rx itu_stream_rx_chk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pixValid   (pixValid),
  .savPulse   (savPulse),
  .eavPulse   (eavPulse),
  .fieldFlag  (fieldFlag),
  .vertFlag   (vertFlag),
  .horzFlag   (horzFlag),
  .parityErr  (parityErr),
  .frameStart (frameStart),
  .errCount   (errCount)
);

// File: tb/itu_stream_rx_tb.sv
`timescale 1ns/1ps
module itu_stream_rx_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] vidIn;
  logic [9:0] yOut, cbOut, crOut;
  logic       pixValid, savPulse, eavPulse, fieldFlag, vertFlag, horzFlag;
  logic       parityErr, frameStart;
  logic [7:0] errCount;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  itu_stream_rx u_dut (
    .clk(clk), .rstN(rstN), .vidIn(vidIn),
    .yOut(yOut), .cbOut(cbOut), .crOut(crOut), .pixValid(pixValid),
    .savPulse(savPulse), .eavPulse(eavPulse),
    .fieldFlag(fieldFlag), .vertFlag(vertFlag), .horzFlag(horzFlag),
    .parityErr(parityErr), .frameStart(frameStart), .errCount(errCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present one word, return at the next falling edge with its result visible
  task automatic step(input logic [9:0] w);
    vidIn = w;
    @(negedge clk);
  endtask

  function automatic logic [9:0] xyWord(input bit f, input bit v, input bit h, input int badBit);
    logic [9:0] w;
    w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    if (badBit >= 0) w[2 + badBit] = ~w[2 + badBit];
    return w;
  endfunction

  task automatic sendCode(input bit f, input bit v, input bit h, input int badBit, input bit eight);
    step(eight ? 10'h3FC : 10'h3FF);
    step(10'h000);
    step(10'h000);
    step(xyWord(f, v, h, badBit));
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    vidIn = 10'h000;
    repeat (3) @(negedge clk);
    chk({yOut, cbOut, crOut, pixValid, savPulse, eavPulse, fieldFlag, vertFlag,
         horzFlag, parityErr, frameStart, errCount} == '0, "R10 reset outputs", int'(pixValid), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_flags();
    sendCode(1'b0, 1'b1, 1'b1, -1, 1'b0);
    chk(eavPulse == 1'b1 && savPulse == 1'b0, "R3 end code pulse", int'({savPulse, eavPulse}), 1);
    chk({fieldFlag, vertFlag, horzFlag} == 3'b011, "R2 flags F0 V1 H1",
        int'({fieldFlag, vertFlag, horzFlag}), 3);
    chk(parityErr == 1'b0, "R4 clean code no error", int'(parityErr), 0);
    step(10'h200);
    chk(eavPulse == 1'b0, "R3 pulse one cycle", int'(eavPulse), 0);
    chk({fieldFlag, vertFlag, horzFlag} == 3'b011, "R2 flags hold", int'({fieldFlag, vertFlag, horzFlag}), 3);
  endtask

  task automatic t_eightbit();
    sendCode(1'b1, 1'b0, 1'b0, -1, 1'b1);
    chk(savPulse == 1'b1 && eavPulse == 1'b0, "R1 padded 3FC preamble", int'({savPulse, eavPulse}), 2);
    chk({fieldFlag, vertFlag, horzFlag} == 3'b100, "R2 flags F1 V0 H0",
        int'({fieldFlag, vertFlag, horzFlag}), 4);
    // broken preamble: second word not zero
    step(10'h3FF); step(10'h010); step(10'h000); step(xyWord(1'b0, 1'b0, 1'b1, -1));
    chk(savPulse == 1'b0 && eavPulse == 1'b0, "R1 broken preamble ignored", int'({savPulse, eavPulse}), 0);
    chk(fieldFlag == 1'b1 && horzFlag == 1'b0, "R1 flags untouched by broken preamble",
        int'({fieldFlag, horzFlag}), 2);
  endtask

  task automatic runLine(input int nGroups, input logic [9:0] base);
    logic [9:0] cb, y0, cr, y1, pCb, pCr, pY1;
    pCb = '0; pCr = '0; pY1 = '0;
    sendCode(1'b0, 1'b0, 1'b0, -1, 1'b0);
    chk(savPulse == 1'b1, "R3 start code pulse", int'(savPulse), 1);
    for (int g = 0; g < nGroups; g++) begin
      cb = base + 10'(g * 8);
      y0 = cb + 10'd1;
      cr = cb + 10'd2;
      y1 = cb + 10'd3;
      step(cb);
      chk(pixValid == 1'b0, "R7 no strobe on Cb", int'(pixValid), 0);
      step(y0);
      if (g > 0) begin
        chk(pixValid == 1'b1 && yOut == pY1 && cbOut == pCb && crOut == pCr,
            "R7 second sample of group", int'(yOut), int'(pY1));
      end
      step(cr);
      chk(pixValid == 1'b0, "R7 no strobe on Cr", int'(pixValid), 0);
      step(y1);
      chk(pixValid == 1'b1 && yOut == y0 && cbOut == cb && crOut == cr,
          "R7 first sample of group", int'({yOut, cbOut, crOut}), int'({y0, cb, cr}));
      pCb = cb; pCr = cr; pY1 = y1;
    end
    step(10'h3FF);
    chk(pixValid == 1'b0, "R7 gap before last sample", int'(pixValid), 0);
    step(10'h000);
    chk(pixValid == 1'b1 && yOut == pY1 && cbOut == pCb, "R7 last sample of line", int'(yOut), int'(pY1));
    step(10'h000);
    step(xyWord(1'b0, 1'b0, 1'b1, -1));
    chk(eavPulse == 1'b1, "R3 line end code", int'(eavPulse), 1);
  endtask

  task automatic t_blank();
    logic [9:0] holdY, holdCb, holdCr;
    bit seen;
    holdY = yOut; holdCb = cbOut; holdCr = crOut;
    seen = 1'b0;
    for (int i = 0; i < 24; i++) begin
      step(10'h080 + 10'(i * 5));
      if (pixValid) seen = 1'b1;
    end
    chk(!seen, "R9 no strobe in blanking", int'(seen), 0);
    chk(yOut == holdY && cbOut == holdCb && crOut == holdCr, "R9 outputs unchanged in blanking",
        int'(yOut), int'(holdY));
  endtask

  task automatic t_restart();
    sendCode(1'b0, 1'b0, 1'b0, -1, 1'b0);
    step(10'h111);
    step(10'h122);
    // cut short in mid-group; new line must realign on Cb
    runLine(3, 10'h140);
    chk(1'b1, "R8 realigned after short line", 0, 0);
  endtask

  task automatic t_frame();
    sendCode(1'b1, 1'b0, 1'b1, -1, 1'b0);
    chk(frameStart == 1'b0, "R5 rising field no frame start", int'(frameStart), 0);
    for (int b = 0; b < 3; b++) begin
      sendCode(1'b1, 1'b0, 1'b1, b, 1'b0);
      chk(parityErr == 1'b1, "R4 single protection bit flipped", int'(parityErr), 1);
    end
    sendCode(1'b1, 1'b1, 1'b0, 3, 1'b0);
    chk(parityErr == 1'b1, "R4 top protection bit flipped", int'(parityErr), 1);
    chk(errCount == 8'd0, "R5 count held mid-frame", int'(errCount), 0);
    sendCode(1'b0, 1'b0, 1'b1, -1, 1'b0);
    chk(frameStart == 1'b1 && errCount == 8'd4, "R5 frame start publishes count",
        int'(errCount), 4);
    step(10'h200);
    chk(frameStart == 1'b0 && errCount == 8'd4, "R5 count holds after frame start", int'(errCount), 4);
    sendCode(1'b0, 1'b0, 1'b0, -1, 1'b0);
    chk(frameStart == 1'b0, "R5 no frame start without fall", int'(frameStart), 0);
    // boundary code itself in error counts toward new frame
    sendCode(1'b1, 1'b0, 1'b1, -1, 1'b0);
    sendCode(1'b0, 1'b0, 1'b1, 1, 1'b0);
    chk(frameStart == 1'b1 && errCount == 8'd0 && parityErr == 1'b1, "R5 failing boundary code",
        int'(errCount), 0);
    sendCode(1'b1, 1'b0, 1'b1, -1, 1'b0);
    sendCode(1'b0, 1'b0, 1'b1, -1, 1'b0);
    chk(errCount == 8'd1, "R5 boundary error in next frame", int'(errCount), 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) sendCode(1'b1, 1'b0, 1'b1, i % 4, 1'b0);
    chk(errCount == 8'd1, "R5 count static during long frame", int'(errCount), 1);
    sendCode(1'b0, 1'b0, 1'b1, -1, 1'b0);
    chk(frameStart == 1'b1 && errCount == 8'd255, "R6 count saturates at 255", int'(errCount), 255);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    vidIn = 10'h000;
    @(negedge clk);
    t_reset();
    t_flags();
    t_eightbit();
    runLine(4, 10'h040);
    t_blank();
    t_restart();
    t_frame();
    t_saturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule